// File: doc/BRIEF.md
# DMA Peripheral Request Pacer

This block paces the peripheral-request side of one DMA channel. For both the source side and the destination side, it watches an external request line. When it sees a request, it raises an internal request (DRQ) toward the transfer engine. It counts the beats the engine reports as done, and it drops DRQ when a block of the configured length has been moved.

Each side is set independently to one of two pacing modes:

- **Wait mode:** the side stays quiet for a programmable number of cycles after each block, then looks for a request again.
- **Handshake mode:** the side flags the final beat of each block with a Last indication. It then waits for the peripheral to raise Active and answers with ACK. It resumes request detection only once Active falls, so each Active pulse buys exactly one further block.

The block length, the wait count and the mode bits are captured only when a block starts. A synchronous channel-enable input lets the controller abort a side at any point.

Top module: `dma_req_pacer`

## Requirements
- R1: In the idle state, a side that samples its external request high at a clock edge drives DRQ high from the next cycle. DRQ stays high until that side has counted as many beat-done strobes as the captured block length. A block length of zero is treated as one beat.
- R2: On the cycle after the beat-done strobe that completes the block, DRQ is low.
- R3: In wait mode (mode bit 0), with the request held high and a wait count W of one or more, DRQ stays low for exactly W+1 cycles between blocks.
- R4: In handshake mode (mode bit 1), Last is high in the DRQ cycle of the final beat and low in the earlier beats. In wait mode, Last is never high.
- R5: In handshake mode, after a block ends, the side keeps DRQ and ACK low until Active is sampled high. ACK is then high from the next cycle.
- R6: ACK stays high while Active stays high, and no new DRQ is raised during that time. On the first edge at which Active is sampled low after being high, ACK drops and the side returns to idle. With the request high, DRQ then rises one cycle later.
- R7: With the request held high in handshake mode, exactly one block is run per Active pulse. No further DRQ appears until the next pulse.
- R8: The two sides are independent. Bit 0 of the mode select controls the source side and bit 1 controls the destination side. In each bit, 0 means wait mode and 1 means handshake mode.
- R9: A wait count of zero in wait mode leaves DRQ low for exactly one cycle between blocks while the request is held.
- R10: The block length, the wait count and the mode are sampled only at the start of a block. Changes while a block runs affect only the next block.
- R11: When the channel enable is sampled low, both sides go idle and DRQ, Last and ACK are low on the next cycle. This also holds when the disable coincides with the final beat of a block, so no wait for Active is left pending.
- R12: After reset, all outputs are low and both sides are idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| chanEn | input | 1 | Channel enable; low forces both sides idle |
| modeSel | input | 2 | Mode per side: bit 0 source, bit 1 destination; 0 wait, 1 handshake |
| blockLen | input | LEN_W | Beats per block (zero counts as one) |
| waitCyc | input | WAIT_W | Idle gap count for wait mode |
| srcExtReq | input | 1 | Source-side external request |
| srcActive | input | 1 | Source-side peripheral Active |
| srcBeatDone | input | 1 | Source-side beat-done strobe from the transfer engine |
| dstExtReq | input | 1 | Destination-side external request |
| dstActive | input | 1 | Destination-side peripheral Active |
| dstBeatDone | input | 1 | Destination-side beat-done strobe |
| srcDrq | output | 1 | Source-side internal request |
| srcLast | output | 1 | Source-side final-beat flag |
| srcAck | output | 1 | Source-side acknowledge to the peripheral |
| dstDrq | output | 1 | Destination-side internal request |
| dstLast | output | 1 | Destination-side final-beat flag |
| dstAck | output | 1 | Destination-side acknowledge |

## Verification
A channel disable can arrive in the same cycle as the beat that completes a handshake-mode block, so the abort and the end-of-block transition compete for the next state. The bench drops the enable exactly during the final-beat cycle. It checks that DRQ, Last and ACK are all low one cycle later. After re-enabling with the request still high, it checks that DRQ returns without any Active pulse, which shows the disable won. A related case changes the length and the mode in the middle of a block, and the bench confirms that they take effect only at the next block start.

// File: rtl/dma_hs_pkg.sv
package dma_hs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_XFER,
    ST_GAP,
    ST_HS_WAIT,
    ST_HS_ACK
  } pacerState_t;

  typedef struct packed {
    logic clear;
    logic loadCfg;
    logic countBeat;
    logic loadTimer;
    logic tickTimer;
  } ctlStrobes_t;

endpackage

// File: rtl/dma_hs_datapath.sv
module dma_hs_datapath
  import dma_hs_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  ctlStrobes_t       stb,
  input  logic [LEN_W-1:0]  blockLen,
  input  logic [WAIT_W-1:0] waitCyc,
  input  logic              modeIn,
  output logic              isLastBeat,
  output logic              waitZero,
  output logic              timerOne,
  output logic              hsMode
);

  localparam logic [LEN_W-1:0]  LEN_ONE  = LEN_W'(1);
  localparam logic [WAIT_W-1:0] WAIT_ONE = WAIT_W'(1);

  logic [LEN_W-1:0]  lenQ;
  logic [LEN_W-1:0]  beatCnt;
  logic [WAIT_W-1:0] waitQ;
  logic [WAIT_W-1:0] gapTimer;
  logic              modeQ;
  logic [LEN_W-1:0]  lenMinusOne;

  // Length and mode captured only at block start
  always_ff @(posedge clk) begin
    if (rst) begin
      lenQ  <= LEN_ONE;
      waitQ <= '0;
      modeQ <= 1'b0;
    end else if (stb.loadCfg) begin
      lenQ  <= (blockLen == '0) ? LEN_ONE : blockLen;
      waitQ <= waitCyc;
      modeQ <= modeIn;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stb.clear || stb.loadCfg) begin
      beatCnt <= '0;
    end else if (stb.countBeat) begin
      beatCnt <= beatCnt + LEN_ONE;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || stb.clear) begin
      gapTimer <= '0;
    end else if (stb.loadTimer) begin
      gapTimer <= waitQ;
    end else if (stb.tickTimer) begin
      gapTimer <= gapTimer - WAIT_ONE;
    end
  end

  assign lenMinusOne = lenQ - LEN_ONE;
  assign isLastBeat  = (beatCnt == lenMinusOne);
  assign waitZero    = (waitQ == '0);
  assign timerOne    = (gapTimer == WAIT_ONE);
  assign hsMode      = modeQ;

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    stb.countBeat |-> (beatCnt < lenMinusOne)); // R1

  AST_TIMER_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    stb.tickTimer |-> (gapTimer != '0)); // R3

endmodule

// File: rtl/dma_hs_ctrl.sv
module dma_hs_ctrl
  import dma_hs_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        chanEn,
  input  logic        extReq,
  input  logic        active,
  input  logic        beatDone,
  input  logic        isLastBeat,
  input  logic        waitZero,
  input  logic        timerOne,
  input  logic        hsMode,
  output ctlStrobes_t stb,
  output logic        drq,
  output logic        lastOut,
  output logic        ack
);

  pacerState_t st, stNxt;
  logic        activeQ;
  logic        activeFell;

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      activeQ <= 1'b0;
    end else begin
      st      <= stNxt;
      activeQ <= active;
    end
  end

  assign activeFell = activeQ && !active;

  always_comb begin
    stNxt = st;
    stb   = '0;
    if (!chanEn) begin
      stb.clear = 1'b1;
      stNxt     = ST_IDLE;
    end else begin
      case (st)
        ST_IDLE: begin
          if (extReq) begin
            stb.loadCfg = 1'b1;
            stNxt       = ST_XFER;
          end
        end
        ST_XFER: begin
          if (beatDone) begin
            if (!isLastBeat) begin
              stb.countBeat = 1'b1;
            end else if (hsMode) begin
              stNxt = ST_HS_WAIT;
            end else if (waitZero) begin
              stNxt = ST_IDLE;
            end else begin
              stb.loadTimer = 1'b1;
              stNxt         = ST_GAP;
            end
          end
        end
        ST_GAP: begin
          stb.tickTimer = 1'b1;
          if (timerOne) stNxt = ST_IDLE;
        end
        ST_HS_WAIT: begin
          if (active) stNxt = ST_HS_ACK;
        end
        ST_HS_ACK: begin
          if (activeFell) stNxt = ST_IDLE;
        end
        default: stNxt = ST_IDLE;
      endcase
    end
  end

  assign drq     = (st == ST_XFER);
  assign lastOut = drq && hsMode && isLastBeat;
  assign ack     = (st == ST_HS_ACK);

  AST_DISABLE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    !chanEn |=> (!drq && !lastOut && !ack)); // R11

  AST_BLOCK_END: assert property (@(posedge clk) disable iff (rst)
    (chanEn && drq && beatDone && isLastBeat) |=> !drq); // R2

  AST_ACK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (chanEn && ack && active) |=> (ack && !drq)); // R6

  AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (chanEn && ack && $fell(active)) |=> !ack); // R6

  AST_LAST_HS_ONLY: assert property (@(posedge clk) disable iff (rst)
    lastOut |-> hsMode); // R4

endmodule

// File: rtl/dma_req_pacer.sv
module dma_req_pacer
  import dma_hs_pkg::*;
#(
  parameter int LEN_W  = 8,
  parameter int WAIT_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chanEn,
  input  logic [1:0]        modeSel,
  input  logic [LEN_W-1:0]  blockLen,
  input  logic [WAIT_W-1:0] waitCyc,
  input  logic              srcExtReq,
  input  logic              srcActive,
  input  logic              srcBeatDone,
  input  logic              dstExtReq,
  input  logic              dstActive,
  input  logic              dstBeatDone,
  output logic              srcDrq,
  output logic              srcLast,
  output logic              srcAck,
  output logic              dstDrq,
  output logic              dstLast,
  output logic              dstAck
);

  localparam int SIDES = 2;

  logic [SIDES-1:0] extReqV, activeV, beatDoneV;
  logic [SIDES-1:0] drqV, lastV, ackV;

  assign extReqV   = {dstExtReq, srcExtReq};
  assign activeV   = {dstActive, srcActive};
  assign beatDoneV = {dstBeatDone, srcBeatDone};

  for (genvar s = 0; s < SIDES; s++) begin : g_side
    ctlStrobes_t stb;
    logic        isLastBeat, waitZero, timerOne, hsMode;

    dma_hs_datapath #(.LEN_W(LEN_W), .WAIT_W(WAIT_W)) u_dp (
      .clk        (clk),
      .rst        (rst),
      .stb        (stb),
      .blockLen   (blockLen),
      .waitCyc    (waitCyc),
      .modeIn     (modeSel[s]),
      .isLastBeat (isLastBeat),
      .waitZero   (waitZero),
      .timerOne   (timerOne),
      .hsMode     (hsMode)
    );

    dma_hs_ctrl u_ctrl (
      .clk        (clk),
      .rst        (rst),
      .chanEn     (chanEn),
      .extReq     (extReqV[s]),
      .active     (activeV[s]),
      .beatDone   (beatDoneV[s]),
      .isLastBeat (isLastBeat),
      .waitZero   (waitZero),
      .timerOne   (timerOne),
      .hsMode     (hsMode),
      .stb        (stb),
      .drq        (drqV[s]),
      .lastOut    (lastV[s]),
      .ack        (ackV[s])
    );
  end

  assign srcDrq  = drqV[0];
  assign srcLast = lastV[0];
  assign srcAck  = ackV[0];
  assign dstDrq  = drqV[1];
  assign dstLast = lastV[1];
  assign dstAck  = ackV[1];

endmodule

// File: tb/dma_req_pacer_bench.sv
`timescale 1ns/1ps
module dma_req_pacer_bench;

  localparam int LEN_W  = 8;
  localparam int WAIT_W = 8;
  localparam int SD = 0, SL = 1, SA = 2, DD = 3, DL = 4, DA = 5;

  typedef struct {
    int    cyc;
    int    sig;
    bit    val;
    string req;
  } expItem_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic chanEn = 1'b1;
  logic [1:0] modeSel = '0;
  logic [LEN_W-1:0] blockLen = '0;
  logic [WAIT_W-1:0] waitCyc = '0;
  logic srcExtReq = 1'b0, srcActive = 1'b0, srcBeatDone = 1'b0;
  logic dstExtReq = 1'b0, dstActive = 1'b0, dstBeatDone = 1'b0;
  logic srcDrq, srcLast, srcAck, dstDrq, dstLast, dstAck;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;
  expItem_t sb[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  dma_req_pacer #(.LEN_W(LEN_W), .WAIT_W(WAIT_W)) u_dma_req_pacer (
    .clk(clk), .rst(rst), .chanEn(chanEn), .modeSel(modeSel),
    .blockLen(blockLen), .waitCyc(waitCyc),
    .srcExtReq(srcExtReq), .srcActive(srcActive), .srcBeatDone(srcBeatDone),
    .dstExtReq(dstExtReq), .dstActive(dstActive), .dstBeatDone(dstBeatDone),
    .srcDrq(srcDrq), .srcLast(srcLast), .srcAck(srcAck),
    .dstDrq(dstDrq), .dstLast(dstLast), .dstAck(dstAck)
  );

  function automatic bit observe(int sig);
    case (sig)
      SD: return srcDrq;
      SL: return srcLast;
      SA: return srcAck;
      DD: return dstDrq;
      DL: return dstLast;
      default: return dstAck;
    endcase
  endfunction

  // Monitor: pops every expectation due in this cycle and compares it
  always @(negedge clk) begin
    for (int i = sb.size() - 1; i >= 0; i--) begin
      if (sb[i].cyc == cyc) begin
        nChecks++;
        if (observe(sb[i].sig) !== sb[i].val) begin
          nFails++;
          $display("FAIL %s cycle %0d signal %0d: actual %b expected %b",
                   sb[i].req, cyc, sb[i].sig, observe(sb[i].sig), sb[i].val);
        end
        sb.delete(i);
      end
    end
  end

  task automatic expectAt(int c, int sig, bit v, string r);
    expItem_t it;
    it.cyc = c; it.sig = sig; it.val = v; it.req = r;
    sb.push_back(it);
  endtask

  task automatic toCyc(int c);
    while (cyc < c) @(negedge clk);
  endtask

  // Disable for one cycle, check all outputs cleared, re-enable (R11)
  task automatic idleAll();
    int c = cyc;
    chanEn = 1'b0;
    srcExtReq = 0; srcActive = 0; srcBeatDone = 0;
    dstExtReq = 0; dstActive = 0; dstBeatDone = 0;
    for (int s = 0; s < 6; s++) expectAt(c + 1, s, 1'b0, "R11");
    toCyc(c + 2);
    chanEn = 1'b1;
  endtask

  initial begin
    #(8 * 5000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    int c0;
    // R12: reset state
    for (int s = 0; s < 6; s++) expectAt(3, s, 1'b0, "R12");
    toCyc(2);
    rst = 1'b0;
    toCyc(4);

    // R1 R2 R3: wait mode, length 3, gap 2
    c0 = cyc;
    modeSel = 2'b00; blockLen = 3; waitCyc = 2;
    srcExtReq = 1; srcBeatDone = 1;
    expectAt(c0 + 1, SD, 1, "R1");
    expectAt(c0 + 2, DD, 0, "R8");
    expectAt(c0 + 3, SD, 1, "R1");
    expectAt(c0 + 3, SL, 0, "R4");
    expectAt(c0 + 4, SD, 0, "R2");
    expectAt(c0 + 6, SD, 0, "R3");
    expectAt(c0 + 7, SD, 1, "R3");
    toCyc(c0 + 8);
    idleAll();

    // R9: zero gap
    c0 = cyc;
    modeSel = 2'b00; blockLen = 2; waitCyc = 0;
    srcExtReq = 1; srcBeatDone = 1;
    expectAt(c0 + 2, SD, 1, "R1");
    expectAt(c0 + 3, SD, 0, "R9");
    expectAt(c0 + 4, SD, 1, "R9");
    toCyc(c0 + 5);
    idleAll();

    // R4 R5 R6 R7: handshake mode
    c0 = cyc;
    modeSel = 2'b01; blockLen = 2; waitCyc = 0;
    srcExtReq = 1; srcBeatDone = 1;
    expectAt(c0 + 1, SL, 0, "R4");
    expectAt(c0 + 2, SL, 1, "R4");
    expectAt(c0 + 3, SD, 0, "R2");
    expectAt(c0 + 5, SD, 0, "R7");
    expectAt(c0 + 5, SA, 0, "R5");
    toCyc(c0 + 5);
    srcActive = 1;
    expectAt(c0 + 6, SA, 1, "R5");
    expectAt(c0 + 8, SA, 1, "R6");
    expectAt(c0 + 8, SD, 0, "R6");
    toCyc(c0 + 8);
    srcActive = 0;
    expectAt(c0 + 9, SA, 0, "R6");
    expectAt(c0 + 10, SD, 1, "R6");
    expectAt(c0 + 14, SD, 0, "R7");
    toCyc(c0 + 15);
    idleAll();

    // R8: independent sides, source wait, destination handshake
    c0 = cyc;
    modeSel = 2'b10; blockLen = 1; waitCyc = 0;
    srcExtReq = 1; srcBeatDone = 1; dstExtReq = 1; dstBeatDone = 1;
    expectAt(c0 + 1, SD, 1, "R8");
    expectAt(c0 + 1, DD, 1, "R8");
    expectAt(c0 + 1, SL, 0, "R8");
    expectAt(c0 + 1, DL, 1, "R8");
    expectAt(c0 + 2, SD, 0, "R8");
    expectAt(c0 + 3, SD, 1, "R8");
    expectAt(c0 + 3, DD, 0, "R8");
    toCyc(c0 + 4);
    idleAll();

    // R10: configuration changed mid-block
    c0 = cyc;
    modeSel = 2'b00; blockLen = 4; waitCyc = 0;
    srcExtReq = 1; srcBeatDone = 1;
    toCyc(c0 + 1);
    modeSel = 2'b01; blockLen = 1; waitCyc = 5;
    expectAt(c0 + 4, SD, 1, "R10");
    expectAt(c0 + 4, SL, 0, "R10");
    expectAt(c0 + 5, SD, 0, "R10");
    expectAt(c0 + 6, SD, 1, "R10");
    expectAt(c0 + 6, SL, 1, "R10");
    expectAt(c0 + 7, SD, 0, "R10");
    toCyc(c0 + 8);
    idleAll();

    // R11: disable coinciding with final handshake beat
    c0 = cyc;
    modeSel = 2'b01; blockLen = 2; waitCyc = 0;
    srcExtReq = 1; srcBeatDone = 1;
    expectAt(c0 + 2, SL, 1, "R4");
    toCyc(c0 + 2);
    chanEn = 0;
    expectAt(c0 + 3, SD, 0, "R11");
    expectAt(c0 + 3, SL, 0, "R11");
    expectAt(c0 + 3, SA, 0, "R11");
    toCyc(c0 + 3);
    chanEn = 1;
    expectAt(c0 + 4, SD, 1, "R11");
    toCyc(c0 + 5);
    idleAll();

    toCyc(cyc + 3);
    foreach (sb[i]) begin
      nFails++;
      $display("FAIL %s cycle %0d signal %0d: actual unchecked expected %b",
               sb[i].req, sb[i].cyc, sb[i].sig, sb[i].val);
    end
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule